// File: doc/BRIEF.md
# Two-Wire Serial Byte-Memory Slave

This block is a slave on a two-wire serial bus. It places an on-chip byte memory on that bus. A parameter sets the memory to 4096 or 8192 bytes. A synchronous system clock oversamples the bus clock and data lines, so the bus clock is treated as data and never used as a clock. The block decodes the select byte that follows a start condition. It answers only when the select byte carries its own address. It then either streams memory bytes out to the master or takes a word address and data bytes in from the master.

A pointer register holds the address of the next byte. It is kept from one transaction to the next. A master can therefore read the next byte with a bare read select and send no address first. The pointer moves by different rules in the two directions:
- Reads step through the whole address space and wrap from the top address to zero.
- Writes step only the five low bits. The page bits above them stay fixed, so a burst of writes circles inside one 32-byte page.

The memory is outside the block. The block drives an address and a one-cycle write strobe, and it expects read data on the clock cycle after the address is presented.

Top module: `tws_eeprom_slave`

## Requirements
- R1: After reset the SDA pull-down enable is 0, the write strobe is 0 and the pointer is 0. The first bare read after reset therefore returns the byte at address 0.
- R2: A select byte is sent MSB first after a start condition. Its upper seven bits are 1,0,1,0 followed by strap[2], strap[1], strap[0], and its last bit is 1 for a read. When the upper seven bits match, the slave pulls SDA low for the whole ninth clock of that byte.
- R3: When the upper seven select bits do not match, the slave never pulls SDA low. It issues no write and ignores every later bit, including bits that form a matching select byte, until the next start condition.
- R4: On a read, the slave shifts out the byte at pointer value n, MSB first, one bit per SCL clock, and changes SDA only while SCL is low. Once the eighth bit has been sent, the pointer becomes n+1.
- R5: When the master pulls SDA low on the ninth clock of a read byte, the slave sends the next byte at the next address. Read addresses step through the whole range and wrap from 2^ADDR_W-1 to 0.
- R6: When the master leaves SDA high on the ninth clock and then sends a stop condition, the slave ends the read and does not pull SDA low again.
- R7: A select byte whose last bit is 0 starts a write. The write is followed by a high word-address byte and then a low word-address byte. The pointer takes the low ADDR_W bits of the two bytes joined together, and any higher bits are ignored. The slave acknowledges each address byte. Each data byte that follows is written to the pointer address with a single-cycle write strobe, and that byte is acknowledged too.
- R8: After each data byte is written, only the low five pointer bits increment, wrapping within the 32-byte page. The bits above them are unchanged.
- R9: The pointer keeps its value across stop and start conditions. After a write ends, a bare read returns the byte that follows the last written one within the same page.
- R10: A start or stop condition in the middle of a byte abandons that byte without any write. A start condition always begins a new select byte.
- R11: The SDA pull-down enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock level seen at the pad |
| sdaIn | input | 1 | Bus data level seen at the pad |
| sdaDriveLow | output | 1 | 1 tells the pad to pull SDA low; 0 releases it |
| strap | input | 3 | Board-strapped low bits of the device select address |
| memAddr | output | ADDR_W | Memory byte address; this is the pointer |
| memWrEn | output | 1 | One-cycle write strobe |
| memWrData | output | 8 | Byte to write |
| memRdData | input | 8 | Byte at memAddr, valid one cycle after the address |

## Verification
The assertions assume a well-behaved master. Each SCL low phase lasts longer than the three-clock synchronizer latency, so every SDA update the slave makes lands while SCL is still low. The master changes SDA only while SCL is low, except when it forms a start or stop condition. It never forms either condition while the slave is pulling SDA low. The bench keeps within these limits by building each bus bit from quarter-periods of four system clocks. The master changes SDA one quarter-period after SCL falls, and start and stop conditions are formed only when the slave has released SDA.

// File: rtl/tws_pkg.sv
package tws_pkg;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WHI,
    ST_WHI_ACK,
    ST_WLO,
    ST_WLO_ACK,
    ST_WDATA,
    ST_WD_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } twsState_t;

  typedef struct packed {
    logic shiftIn;
    logic clrBits;
    logic ackOn;
    logic clrDrive;
    logic loadHi;
    logic loadLo;
    logic writeMem;
    logic incWrite;
    logic incRead;
    logic loadTx;
    logic shiftOut;
  } twsStrobes_t;

endpackage

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [2:0]  strap,
  input  logic [7:0]  rxByte,
  input  logic        byteFull,
  output twsStrobes_t stb,
  output logic        sdaBit
);

  logic [2:0] sclSync, sdaSync;
  logic sclNow, sclOld, sdaNow, sdaOld;
  logic sclRise, sclFall, startCond, stopCond, devMatch;

  twsState_t state, stateNext;
  logic isRead, isReadNext;
  logic masterAck, masterAckNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
    end else begin
      sclSync <= {sclSync[1:0], sclIn};
      sdaSync <= {sdaSync[1:0], sdaIn};
    end
  end

  assign sclNow    = sclSync[1];
  assign sclOld    = sclSync[2];
  assign sdaNow    = sdaSync[1];
  assign sdaOld    = sdaSync[2];
  assign sclRise   = sclNow & ~sclOld;
  assign sclFall   = ~sclNow & sclOld;
  assign startCond = sclNow & sclOld & sdaOld & ~sdaNow;
  assign stopCond  = sclNow & sclOld & ~sdaOld & sdaNow;
  assign sdaBit    = sdaNow;
  assign devMatch  = (rxByte[7:1] == {DEV_PREFIX, strap});

  always_comb begin
    stb           = '0;
    stateNext     = state;
    isReadNext    = isRead;
    masterAckNext = masterAck;
    if (stopCond) begin
      stateNext    = ST_IDLE;
      stb.clrBits  = 1'b1;
      stb.clrDrive = 1'b1;
    end else if (startCond) begin
      stateNext    = ST_DEV;
      stb.clrBits  = 1'b1;
      stb.clrDrive = 1'b1;
    end else begin
      case (state)
        ST_DEV, ST_WHI, ST_WLO, ST_WDATA: begin
          if (sclRise && !byteFull) begin
            stb.shiftIn = 1'b1;
          end else if (sclFall && byteFull) begin
            case (state)
              ST_DEV: begin
                if (devMatch) begin
                  stb.ackOn  = 1'b1;
                  isReadNext = rxByte[0];
                  stateNext  = ST_DEV_ACK;
                end else begin
                  stateNext  = ST_IGNORE;
                end
              end
              ST_WHI: begin
                stb.loadHi = 1'b1;
                stb.ackOn  = 1'b1;
                stateNext  = ST_WHI_ACK;
              end
              ST_WLO: begin
                stb.loadLo = 1'b1;
                stb.ackOn  = 1'b1;
                stateNext  = ST_WLO_ACK;
              end
              default: begin
                stb.writeMem = 1'b1;
                stb.ackOn    = 1'b1;
                stateNext    = ST_WD_ACK;
              end
            endcase
          end
        end
        ST_DEV_ACK: begin
          if (sclFall) begin
            stb.clrBits = 1'b1;
            if (isRead) begin
              stb.loadTx = 1'b1;
              stateNext  = ST_RDATA;
            end else begin
              stb.clrDrive = 1'b1;
              stateNext    = ST_WHI;
            end
          end
        end
        ST_WHI_ACK: begin
          if (sclFall) begin
            stb.clrDrive = 1'b1;
            stb.clrBits  = 1'b1;
            stateNext    = ST_WLO;
          end
        end
        ST_WLO_ACK: begin
          if (sclFall) begin
            stb.clrDrive = 1'b1;
            stb.clrBits  = 1'b1;
            stateNext    = ST_WDATA;
          end
        end
        ST_WD_ACK: begin
          if (sclFall) begin
            stb.clrDrive = 1'b1;
            stb.clrBits  = 1'b1;
            stb.incWrite = 1'b1;
            stateNext    = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (sclRise && !byteFull) begin
            stb.shiftIn = 1'b1;
          end else if (sclFall) begin
            if (byteFull) begin
              stb.clrDrive = 1'b1;
              stb.incRead  = 1'b1;
              stb.clrBits  = 1'b1;
              stateNext    = ST_RACK;
            end else begin
              stb.shiftOut = 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            masterAckNext = ~sdaNow;
          end else if (sclFall) begin
            if (masterAck) begin
              stb.loadTx = 1'b1;
              stateNext  = ST_RDATA;
            end else begin
              stateNext  = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      isRead    <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state     <= stateNext;
      isRead    <= isReadNext;
      masterAck <= masterAckNext;
    end
  end

endmodule

// File: rtl/tws_datapath.sv
module tws_datapath
  import tws_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PAGE_BITS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  twsStrobes_t       stb,
  input  logic              sdaBit,
  input  logic [7:0]        memRdData,
  output logic [7:0]        rxByte,
  output logic              byteFull,
  output logic              sdaDriveLow,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [7:0]        memWrData,
  output logic [ADDR_W-1:0] curPtr
);

  localparam int HI_W = ADDR_W - 8;

  logic [3:0]        bitCnt;
  logic [7:0]        rxReg;
  logic [7:0]        txReg;
  logic              ackLow;
  logic              txActive;
  logic [ADDR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      rxReg  <= '0;
    end else if (stb.clrBits) begin
      bitCnt <= '0;
    end else if (stb.shiftIn) begin
      bitCnt <= bitCnt + 4'd1;
      rxReg  <= {rxReg[6:0], sdaBit};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg    <= '1;
      ackLow   <= 1'b0;
      txActive <= 1'b0;
    end else if (stb.loadTx) begin
      txReg    <= memRdData;
      txActive <= 1'b1;
      ackLow   <= 1'b0;
    end else if (stb.clrDrive) begin
      ackLow   <= 1'b0;
      txActive <= 1'b0;
    end else if (stb.ackOn) begin
      ackLow   <= 1'b1;
    end else if (stb.shiftOut) begin
      txReg    <= {txReg[6:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (stb.loadHi) begin
      ptr[ADDR_W-1:8] <= rxReg[HI_W-1:0];
    end else if (stb.loadLo) begin
      ptr[7:0] <= rxReg;
    end else if (stb.incRead) begin
      ptr <= ptr + 1'b1;
    end else if (stb.incWrite) begin
      ptr[PAGE_BITS-1:0] <= ptr[PAGE_BITS-1:0] + 1'b1;
    end
  end

  assign rxByte      = rxReg;
  assign byteFull    = (bitCnt == 4'd8);
  assign sdaDriveLow = ackLow | (txActive & ~txReg[7]);
  assign memAddr     = ptr;
  assign memWrEn     = stb.writeMem;
  assign memWrData   = rxReg;
  assign curPtr      = ptr;

endmodule

// File: rtl/tws_eeprom_slave.sv
module tws_eeprom_slave
  import tws_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PAGE_BITS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  input  logic [2:0]        strap,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [7:0]        memWrData,
  input  logic [7:0]        memRdData
);

  twsStrobes_t       stb;
  logic              sdaBit;
  logic [7:0]        rxByte;
  logic              byteFull;
  logic [ADDR_W-1:0] curPtr;

  tws_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .strap    (strap),
    .rxByte   (rxByte),
    .byteFull (byteFull),
    .stb      (stb),
    .sdaBit   (sdaBit)
  );

  tws_datapath #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .sdaBit      (sdaBit),
    .memRdData   (memRdData),
    .rxByte      (rxByte),
    .byteFull    (byteFull),
    .sdaDriveLow (sdaDriveLow),
    .memAddr     (memAddr),
    .memWrEn     (memWrEn),
    .memWrData   (memWrData),
    .curPtr      (curPtr)
  );

endmodule

// File: rtl/tws_eeprom_slave_chk.sv
module tws_eeprom_slave_chk #(
  parameter int ADDR_W    = 12,
  parameter int PAGE_BITS = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaDriveLow,
  input logic              memWrEn,
  input logic              incRead,
  input logic              incWrite,
  input logic [ADDR_W-1:0] curPtr
);

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclIn); // R11

  AST_READ_FULL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    incRead |=> curPtr == ADDR_W'($past(curPtr) + 1'b1)); // R4

  AST_WRITE_PAGE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    incWrite |=> curPtr[ADDR_W-1:PAGE_BITS] == $past(curPtr[ADDR_W-1:PAGE_BITS])); // R8

  AST_WRITE_LOW_STEP: assert property (@(posedge clk) disable iff (!rstN)
    incWrite |=> curPtr[PAGE_BITS-1:0] == PAGE_BITS'($past(curPtr[PAGE_BITS-1:0]) + 1'b1)); // R8

  AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> !memWrEn); // R7

  AST_WRITE_QUIET_BUS: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (!sclIn && !sdaDriveLow)); // R7

endmodule

bind tws_eeprom_slave tws_eeprom_slave_chk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sclIn       (sclIn),
  .sdaDriveLow (sdaDriveLow),
  .memWrEn     (memWrEn),
  .incRead     (stb.incRead),
  .incWrite    (stb.incWrite),
  .curPtr      (curPtr)
);

// File: tb/tws_eeprom_slave_test.sv
module tws_eeprom_slave_test;

  localparam int ADDR_W = 12;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int Q      = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rstN;
  logic              scl = 1'b1;
  logic              mSda = 1'b1;
  logic              sdaBus;
  logic              sdaDriveLow;
  logic [2:0]        strap = 3'b101;
  logic [ADDR_W-1:0] memAddr;
  logic              memWrEn;
  logic [7:0]        memWrData;
  logic [7:0]        memRdData;

  assign sdaBus = mSda & ~sdaDriveLow;

  tws_eeprom_slave #(.ADDR_W(ADDR_W), .PAGE_BITS(5)) uut (
    .clk         (clk),
    .rstN        (rstN),
    .sclIn       (scl),
    .sdaIn       (sdaBus),
    .sdaDriveLow (sdaDriveLow),
    .strap       (strap),
    .memAddr     (memAddr),
    .memWrEn     (memWrEn),
    .memWrData   (memWrData),
    .memRdData   (memRdData)
  );

  logic [7:0] benchMem [DEPTH];
  logic [7:0] refMem   [DEPTH];

  function automatic logic [7:0] seedVal(input int i);
    return 8'(((i * 37) ^ (i >> 4)) + 8'h5A);
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      benchMem[i] = seedVal(i);
      refMem[i]   = seedVal(i);
    end
  end

  always @(posedge clk) begin
    if (memWrEn) benchMem[memAddr] <= memWrData;
    memRdData <= benchMem[memAddr];
  end

  int checks = 0;
  int fails  = 0;
  int ptrModel = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // write monitor: every strobe must be one the bench expects
  logic              expectWr = 1'b0;
  logic [ADDR_W-1:0] expWrAddr = '0;
  logic [7:0]        expWrData = '0;
  always @(negedge clk) begin
    if (rstN === 1'b1 && memWrEn) begin
      check(expectWr && memAddr == expWrAddr && memWrData == expWrData,
            "R7/R8 write address/data", int'(memAddr), int'(expWrAddr));
      expectWr = 1'b0;
    end
  end

  // SDA pull-down may only move while SCL is low
  logic prevDrive = 1'b0;
  always @(negedge clk) begin
    if (rstN === 1'b1 && sdaDriveLow != prevDrive && scl)
      check(1'b0, "R11 SDA moved with SCL high", 1, 0);
    prevDrive = sdaDriveLow;
  end

  task automatic busStart();
    mSda = 1'b1; waitCyc(Q);
    scl  = 1'b1; waitCyc(Q);
    mSda = 1'b0; waitCyc(Q);
    scl  = 1'b0; waitCyc(Q);
  endtask

  task automatic busStop();
    mSda = 1'b0; waitCyc(Q);
    scl  = 1'b1; waitCyc(Q);
    mSda = 1'b1; waitCyc(2 * Q);
  endtask

  task automatic sendBit(input bit b);
    mSda = b;    waitCyc(Q);
    scl  = 1'b1; waitCyc(2 * Q);
    scl  = 1'b0; waitCyc(Q);
  endtask

  task automatic getBit(output bit b);
    mSda = 1'b1; waitCyc(Q);
    scl  = 1'b1; waitCyc(Q);
    b = sdaBus;  waitCyc(Q);
    scl  = 1'b0; waitCyc(Q);
  endtask

  task automatic writeByte(input logic [7:0] v, output bit ack);
    bit a;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    getBit(a);
    ack = !a;
  endtask

  task automatic readByte(output logic [7:0] d, input bit giveAck);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      getBit(b);
      d[i] = b;
    end
    sendBit(!giveAck);
  endtask

  function automatic logic [6:0] devSel();
    return {4'b1010, strap};
  endfunction

  task automatic readBytes(input int n, input string tag);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      readByte(d, k < n - 1);
      check(d == refMem[ptrModel], tag, int'(d), int'(refMem[ptrModel]));
      ptrModel = (ptrModel + 1) % DEPTH;
    end
    busStop();
    waitCyc(2);
    check(!sdaDriveLow, "R6 SDA released after NACK and stop", int'(sdaDriveLow), 0);
  endtask

  task automatic bareRead(input int n, input string tag);
    bit ack;
    busStart();
    writeByte({devSel(), 1'b1}, ack);
    check(ack, "R2 read select acknowledged", int'(ack), 1);
    readBytes(n, tag);
  endtask

  task automatic setPointer(input logic [7:0] hi, input logic [7:0] lo);
    bit ack;
    busStart();
    writeByte({devSel(), 1'b0}, ack);
    check(ack, "R2 write select acknowledged", int'(ack), 1);
    writeByte(hi, ack);
    check(ack, "R7 high address acknowledged", int'(ack), 1);
    writeByte(lo, ack);
    check(ack, "R7 low address acknowledged", int'(ack), 1);
    ptrModel = int'({hi, lo}) & (DEPTH - 1);
  endtask

  task automatic writeData(input logic [7:0] d);
    bit ack;
    expectWr  = 1'b1;
    expWrAddr = ADDR_W'(ptrModel);
    expWrData = d;
    writeByte(d, ack);
    check(ack, "R7 data byte acknowledged", int'(ack), 1);
    check(!expectWr, "R7 write strobe issued", int'(expectWr), 0);
    refMem[ptrModel] = d;
    ptrModel = (ptrModel & ~31) | ((ptrModel + 1) & 31);   // R8
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R10 actual=running expected=done");
    finishRun();
  end

  initial begin
    bit ack;
    rstN = 1'b0;
    waitCyc(5);
    check(!sdaDriveLow && !memWrEn, "R1 outputs idle in reset",
          int'({sdaDriveLow, memWrEn}), 0);
    rstN = 1'b1;
    waitCyc(5);

    // R1: pointer starts at 0
    bareRead(1, "R1 first bare read from address 0");

    // R2 / R3: sweep every select address with strap 101
    for (int a = 0; a < 128; a++) begin
      bit match;
      match = (7'(a) == devSel());
      busStart();
      writeByte({7'(a), 1'b1}, ack);
      check(ack == match, "R2/R3 select acknowledge", int'(ack), int'(match));
      if (match) begin
        readBytes(1, "R4 bare read data and pointer step");
      end else begin
        writeByte({devSel(), 1'b1}, ack);
        check(!ack, "R3 ignored until next start", int'(ack), 0);
        busStop();
      end
    end

    // strap change: new address answers, old one does not
    strap = 3'b010;
    waitCyc(4);
    busStart();
    writeByte({7'b1010101, 1'b1}, ack);
    check(!ack, "R3 old strap address silent", int'(ack), 0);
    busStop();
    bareRead(2, "R2 new strap read data");

    // page write with ignored high bits and in-page wrap
    setPointer(8'hF3, 8'h1D);
    check(ptrModel == 12'h31D, "R7 high bits ignored in model", ptrModel, 12'h31D);
    for (int k = 0; k < 6; k++) writeData(8'(8'hC0 + k));
    busStop();
    bareRead(1, "R9 pointer kept after page write");

    // read steps across the page boundary
    setPointer(8'h03, 8'h1D);
    busStart();
    writeByte({devSel(), 1'b1}, ack);
    check(ack, "R2 repeated-start read select", int'(ack), 1);
    readBytes(6, "R5 sequential read crosses page");

    setPointer(8'h03, 8'h00);
    busStop();
    bareRead(3, "R8 wrapped bytes landed at page start");

    // read wrap at top of memory
    setPointer(8'h0F, 8'hFE);
    busStop();
    bareRead(4, "R5 read wraps to address 0");

    // write wrap at top page
    setPointer(8'h0F, 8'hFE);
    for (int k = 0; k < 3; k++) writeData(8'(8'h71 + k));
    busStop();
    bareRead(1, "R8 write pointer stayed in top page");
    setPointer(8'h0F, 8'hE0);
    busStop();
    bareRead(1, "R8 third byte written at page base");

    // stop in the middle of a data byte
    setPointer(8'h00, 8'h10);
    for (int k = 0; k < 4; k++) sendBit(k[0]);
    busStop();
    bareRead(1, "R10 stop mid-byte left memory and pointer");

    // start in the middle of a data byte
    setPointer(8'h00, 8'h20);
    for (int k = 0; k < 3; k++) sendBit(1'b0);
    busStart();
    writeByte({devSel(), 1'b1}, ack);
    check(ack, "R10 start mid-byte begins new select", int'(ack), 1);
    readBytes(2, "R10 read after mid-byte restart");

    waitCyc(10);
    finishRun();
  end

endmodule